// File: doc/BRIEF.md
# Three-Phase Bridge Gate Sequencer

This block turns per-leg command inputs for a three-leg half-bridge into six registered gate-enable outputs, one highside and one lowside per leg. In its guarded mode the lowside command of each leg has priority. That lowside command alone selects which switch of the leg conducts, so the highside command has no effect. A programmable dead time separates switching one device off from switching its partner on.

A bypass control, or a dead-time count of zero, makes each output copy its command directly. In that mode no overlap guard is applied, and avoiding shoot-through is the job of the driving logic. Two conditions force all six gates low: an active-low enable input held high, and an undervoltage lockout. The lockout is latched from two threshold flags that have already been compared upstream, which gives hysteresis.

All asynchronous inputs pass through a two-flop synchronizer. The dead-time count and the bypass control are quasi-static configuration values, registered once inside the block.

Top module: `bridge_gate_seq`

## Requirements
- R1: While reset is asserted, and after it until enable and lockout release allow otherwise, all six gate outputs are low. The lockout starts in the locked state.
- R2: When `en_n` is 1, all gate outputs go low on the third rising edge after the change, whatever the other inputs are.
- R3: In guarded mode (bypass 0, dead count nonzero), `lo_cmd[i]`=1 turns on the lowside of leg i and keeps its highside off. `lo_cmd[i]`=0 turns on the highside. `hi_cmd[i]` has no effect in this mode.
- R4: In guarded mode, `hi_gate[i]` and `lo_gate[i]` are never both 1.
- R5: In guarded mode, after one switch of a leg goes off, its partner turns on exactly D rising edges later, where D is the dead-time count. A larger D gives a longer gap.
- R6: With `dt_bypass`=1 or a dead count of 0, `hi_gate` equals `hi_cmd` and `lo_gate` equals `lo_cmd`. Both switches of a leg may then be on together.
- R7: `uv_below`=1 locks the gates low, starting on the fourth rising edge after the flag changes. With both flags 0 the lockout holds its state. `uv_above`=1 with `uv_below`=0 releases it.
- R8: After the enable is restored or the lockout is released, no switch turns on until a full dead-time interval has elapsed. With enable, the switch turns on D edges after the edge on which the synchronized enable changes. With the lockout, it turns on D edges after the edge on which the lockout clears.
- R9: A highside switch commanded on stays on for as long as the command holds, with no limit on its on-time.
- R10: A command change reaches the gate outputs on the third rising edge after it is applied: two synchronizer stages plus the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_cmd | input | NUM_LEGS | Lowside command per leg (idle level 1) |
| hi_cmd | input | NUM_LEGS | Highside command per leg (idle level 1) |
| en_n | input | 1 | Active-low bridge enable (idle level 1 disables) |
| uv_below | input | 1 | Bias below the falling undervoltage threshold |
| uv_above | input | 1 | Bias above the rising undervoltage threshold |
| dead_cnt | input | DT_W | Dead time in clock cycles; 0 selects direct follow |
| dt_bypass | input | 1 | 1 = outputs follow the commands directly |
| hi_gate | output | NUM_LEGS | Highside gate enable per leg |
| lo_gate | output | NUM_LEGS | Lowside gate enable per leg |

## Verification
A command or enable change is due at the outputs on the third rising edge after it is applied. A lockout flag change is due on the fourth edge. A turn-on in guarded mode comes D edges after the partner switch went off, or D edges after the forcing condition clears. The bench drives inputs on falling edges and counts rising edges from there. For each timing check it samples on the falling edge just before the due edge and again just after it, so an early and a late change are both caught. The table-driven cases first hold each setting for thirty cycles and then check only the settled outputs.

// File: rtl/bridge_gate_pkg.sv
`timescale 1ns/1ps
package bridge_gate_pkg;
  // Which switch of a leg the guarded logic wants on.
  typedef enum logic [1:0] {
    LEG_OFF  = 2'd0,
    LEG_LOW  = 2'd1,
    LEG_HIGH = 2'd2
  } leg_req_t;

  // The lowside command decides alone: 1 selects the lowside, 0 the highside.
  function automatic leg_req_t leg_request(input logic lo_cmd);
    return lo_cmd ? LEG_LOW : LEG_HIGH;
  endfunction
endpackage

// File: rtl/bg_sync.sv
`timescale 1ns/1ps
module bg_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/bg_lockout.sv
`timescale 1ns/1ps
module bg_lockout (
  input  logic clk,
  input  logic rst,
  input  logic below_s,
  input  logic above_s,
  output logic locked
);
  always_ff @(posedge clk) begin
    if (rst)          locked <= 1'b1;
    else if (below_s) locked <= 1'b1;
    else if (above_s) locked <= 1'b0;
  end

  assert_lock_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!below_s && !above_s) |=> $stable(locked));
  assert_lock_set_R7: assert property (@(posedge clk) disable iff (rst)
    below_s |=> locked);
endmodule

// File: rtl/bg_leg.sv
`timescale 1ns/1ps
module bg_leg
  import bridge_gate_pkg::*;
#(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            force_off,
  input  logic            bypass,
  input  logic            lo_s,
  input  logic            hi_s,
  input  logic [DT_W-1:0] dead,
  output logic            hi_q,
  output logic            lo_q
);
  logic [DT_W-1:0] gap_cnt;
  logic [DT_W-1:0] dead_m1;
  leg_req_t        want;
  logic            drop;
  logic            idle;

  assign dead_m1 = dead - 1'b1;
  assign want    = leg_request(lo_s);
  assign drop    = (lo_q && want != LEG_LOW) || (hi_q && want != LEG_HIGH);
  assign idle    = !hi_q && !lo_q;

  always_ff @(posedge clk) begin
    if (rst || force_off) begin
      hi_q    <= 1'b0;
      lo_q    <= 1'b0;
      gap_cnt <= '0;
    end else if (bypass) begin
      hi_q    <= hi_s;
      lo_q    <= lo_s;
      gap_cnt <= '0;
    end else if (drop) begin
      hi_q    <= 1'b0;
      lo_q    <= 1'b0;
      gap_cnt <= '0;
    end else if (idle) begin
      if (gap_cnt >= dead_m1) begin
        lo_q <= (want == LEG_LOW);
        hi_q <= (want == LEG_HIGH);
      end else begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  // R4: no overlap when the last update ran in guarded mode
  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(bypass) |-> !(hi_q && lo_q));
  // R5: a switch only rises after its partner was already off
  assert_gap_hi_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(hi_q) && !$past(bypass)) |-> !$past(lo_q));
  assert_gap_lo_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(lo_q) && !$past(bypass)) |-> !$past(hi_q));
  // R8: no turn-on straight out of a forced-off cycle
  assert_release_gap_R8: assert property (@(posedge clk) disable iff (rst)
    (($rose(hi_q) || $rose(lo_q)) && !$past(bypass)) |-> !$past(force_off));
endmodule

// File: rtl/bridge_gate_seq.sv
`timescale 1ns/1ps
module bridge_gate_seq #(
  parameter int NUM_LEGS = 3,
  parameter int DT_W     = 4,
  parameter int DEAD_RST = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_LEGS-1:0] lo_cmd,
  input  logic [NUM_LEGS-1:0] hi_cmd,
  input  logic                en_n,
  input  logic                uv_below,
  input  logic                uv_above,
  input  logic [DT_W-1:0]     dead_cnt,
  input  logic                dt_bypass,
  output logic [NUM_LEGS-1:0] hi_gate,
  output logic [NUM_LEGS-1:0] lo_gate
);
  localparam int SW = 2 * NUM_LEGS + 3;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, 1'b1, {NUM_LEGS{1'b1}}, {NUM_LEGS{1'b1}}};

  logic [SW-1:0]       raw_in;
  logic [SW-1:0]       sync_out;
  logic [NUM_LEGS-1:0] lo_s, hi_s;
  logic                en_s, below_s, above_s;
  logic                locked;
  logic                force_off;
  logic [DT_W-1:0]     dead_r;
  logic                byp_r;
  logic                direct;

  assign raw_in = {uv_above, uv_below, en_n, hi_cmd, lo_cmd};

  bg_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_out)
  );

  assign lo_s    = sync_out[NUM_LEGS-1:0];
  assign hi_s    = sync_out[2*NUM_LEGS-1:NUM_LEGS];
  assign en_s    = sync_out[2*NUM_LEGS];
  assign below_s = sync_out[2*NUM_LEGS+1];
  assign above_s = sync_out[2*NUM_LEGS+2];

  // Quasi-static configuration, registered once.
  always_ff @(posedge clk) begin
    if (rst) begin
      dead_r <= DT_W'(DEAD_RST);
      byp_r  <= 1'b0;
    end else begin
      dead_r <= dead_cnt;
      byp_r  <= dt_bypass;
    end
  end

  assign direct = byp_r || (dead_r == '0);

  bg_lockout u_lock (
    .clk(clk), .rst(rst), .below_s(below_s), .above_s(above_s), .locked(locked)
  );

  assign force_off = en_s || locked;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    bg_leg #(.DT_W(DT_W)) u_leg (
      .clk(clk), .rst(rst), .force_off(force_off), .bypass(direct),
      .lo_s(lo_s[g]), .hi_s(hi_s[g]), .dead(dead_r),
      .hi_q(hi_gate[g]), .lo_q(lo_gate[g])
    );
  end

  assert_en_off_R2: assert property (@(posedge clk) disable iff (rst)
    $past(en_s) |-> (hi_gate == '0 && lo_gate == '0));
  assert_lock_off_R7: assert property (@(posedge clk) disable iff (rst)
    $past(locked) |-> (hi_gate == '0 && lo_gate == '0));
endmodule

// File: tb/bridge_gate_seq_tb.sv
`timescale 1ns/1ps
module bridge_gate_seq_tb;
  localparam int N  = 3;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  lo_cmd = '1, hi_cmd = '1;
  logic          en_n = 1'b1, uv_below = 1'b0, uv_above = 1'b0;
  logic [DW-1:0] dead_cnt = 4'd4;
  logic          dt_bypass = 1'b0;
  logic [N-1:0]  hi_gate, lo_gate;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  bridge_gate_seq #(.NUM_LEGS(N), .DT_W(DW), .DEAD_RST(4)) u_dut (
    .clk(clk), .rst(rst), .lo_cmd(lo_cmd), .hi_cmd(hi_cmd), .en_n(en_n),
    .uv_below(uv_below), .uv_above(uv_above), .dead_cnt(dead_cnt),
    .dt_bypass(dt_bypass), .hi_gate(hi_gate), .lo_gate(lo_gate)
  );

  // {byp, dead[3:0], en_n, lo[2:0], hi[2:0], exp_hi[2:0], exp_lo[2:0]}
  localparam logic [17:0] VEC [8] = '{
    {1'b0, 4'd4, 1'b0, 3'b101, 3'b000, 3'b010, 3'b101},  // R3 complementary
    {1'b0, 4'd4, 1'b0, 3'b111, 3'b111, 3'b000, 3'b111},  // R3 lowside priority
    {1'b0, 4'd4, 1'b0, 3'b000, 3'b010, 3'b111, 3'b000},  // R3 hi cmd no effect
    {1'b0, 4'd4, 1'b1, 3'b010, 3'b101, 3'b000, 3'b000},  // R2 disabled
    {1'b1, 4'd4, 1'b0, 3'b011, 3'b110, 3'b110, 3'b011},  // R6 bypass overlap
    {1'b0, 4'd0, 1'b0, 3'b100, 3'b101, 3'b101, 3'b100},  // R6 zero count
    {1'b0, 4'd7, 1'b0, 3'b010, 3'b111, 3'b101, 3'b010},  // R3 long dead
    {1'b1, 4'd3, 1'b1, 3'b111, 3'b111, 3'b000, 3'b000}   // R2 idle levels
  };

  task automatic check(input bit ok, input string req, input logic [5:0] act,
                       input logic [5:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: {hi,lo} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic expect_out(input string req, input logic [N-1:0] eh,
                            input logic [N-1:0] el);
    check(hi_gate === eh && lo_gate === el, req, {hi_gate, lo_gate}, {eh, el});
  endtask

  task automatic edges(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    edges(3);
    expect_out("R1 during reset", 3'b000, 3'b000);
    rst = 1'b0;
    en_n = 1'b0; lo_cmd = 3'b000; hi_cmd = 3'b000;
    edges(20);
    expect_out("R1 locked after reset", 3'b000, 3'b000);
    uv_above = 1'b1;
    edges(30);
    expect_out("R7 released", 3'b111, 3'b000);

    // Table walk: settled outputs
    for (int i = 0; i < 8; i++) begin
      dt_bypass = VEC[i][17];
      dead_cnt  = VEC[i][16:13];
      en_n      = VEC[i][12];
      lo_cmd    = VEC[i][11:9];
      hi_cmd    = VEC[i][8:6];
      edges(30);
      expect_out($sformatf("R3/R6/R2 vector %0d", i), VEC[i][5:3], VEC[i][2:0]);
    end

    // R5 / R10: exact dead-time gap, D = 5
    dt_bypass = 1'b0; en_n = 1'b0; dead_cnt = 4'd5; hi_cmd = 3'b000;
    lo_cmd = 3'b001;
    edges(30);
    expect_out("R5 setup", 3'b110, 3'b001);
    lo_cmd = 3'b000;
    edges(2);
    expect_out("R10 before third edge", 3'b110, 3'b001);
    edges(1);
    expect_out("R5 both off after turn-off", 3'b110, 3'b000);
    edges(4);
    expect_out("R5 still off at D-1", 3'b110, 3'b000);
    edges(1);
    expect_out("R5 highside on at D", 3'b111, 3'b000);

    // R9: highside held on for a long time
    begin
      bit held = 1'b1;
      for (int c = 0; c < 2000; c++) begin
        edges(1);
        if (hi_gate[0] !== 1'b1) held = 1'b0;
      end
      check(held, "R9 highside 100% on", {hi_gate, lo_gate}, 6'b111000);
    end

    // R5: shorter dead time, D = 2
    dead_cnt = 4'd2;
    edges(5);
    lo_cmd = 3'b001;
    edges(3);
    expect_out("R5 off edge D=2", 3'b110, 3'b000);
    edges(1);
    expect_out("R5 still off D=2", 3'b110, 3'b000);
    edges(1);
    expect_out("R5 lowside on D=2", 3'b110, 3'b001);

    // R2 / R8: enable latency and release gap, D = 3
    dead_cnt = 4'd3;
    edges(10);
    en_n = 1'b1;
    edges(2);
    expect_out("R2 before third edge", 3'b110, 3'b001);
    edges(1);
    expect_out("R2 forced off", 3'b000, 3'b000);
    edges(5);
    en_n = 1'b0;
    edges(4);
    expect_out("R8 enable release still off", 3'b000, 3'b000);
    edges(1);
    expect_out("R8 enable release on", 3'b110, 3'b001);

    // R7 / R8: lockout latency, hysteresis, release gap
    uv_above = 1'b0; uv_below = 1'b1;
    edges(3);
    expect_out("R7 before fourth edge", 3'b110, 3'b001);
    edges(1);
    expect_out("R7 locked off", 3'b000, 3'b000);
    uv_below = 1'b0;
    edges(30);
    expect_out("R7 hysteresis holds", 3'b000, 3'b000);
    uv_above = 1'b1;
    edges(5);
    expect_out("R8 lockout release still off", 3'b000, 3'b000);
    edges(1);
    expect_out("R8 lockout release on", 3'b110, 3'b001);

    // R6 / R10: bypass latency
    dt_bypass = 1'b1; lo_cmd = 3'b000; hi_cmd = 3'b000;
    edges(10);
    expect_out("R6 bypass idle", 3'b000, 3'b000);
    hi_cmd = 3'b100; lo_cmd = 3'b100;
    edges(2);
    expect_out("R10 bypass before third edge", 3'b000, 3'b000);
    edges(1);
    expect_out("R6 bypass follows", 3'b100, 3'b100);

    // R4: leaving bypass with overlap drops both, then sequences
    dt_bypass = 1'b0; dead_cnt = 4'd2;
    edges(10);
    expect_out("R4 guarded after bypass", 3'b011, 3'b100);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule